// File: doc/BRIEF.md
# 4x4 Inverse Transform and Reconstruction Engine

This block turns sixteen signed transform coefficients and a 4x4 predicted pixel block into a reconstructed 4x4 pixel block. It first runs a column butterfly over the coefficients into a bank of sixteen temporaries. It then runs a row butterfly over those temporaries, scales each result down by eight, adds it to the predicted pixel at the same position and clamps the sum to the 8-bit range. An optional mode reconstructs a second block immediately to the right of the first in the same command, taking the upper sixteen coefficients.

Coefficients are loaded one at a time through an indexed write port while the engine is idle. A start pulse latches a base byte address and the mode. The engine reads predicted pixels from a byte-wide buffer with a fixed row pitch through a synchronous read port, and writes finished pixels back through a write port. Because every pixel is read exactly one cycle before it is written, the predicted block and the destination may be the same bytes. A one-cycle done pulse marks the end of the command.

Top module: `itx4_recon`

## Requirements
- R1: After reset, busy, done, rd_en and wr_en are all low.
- R2: A start pulse while idle latches base_addr and two_blk and raises busy on the next cycle. A start pulse while busy has no effect on the running command or its addresses.
- R3: While idle, coef_we writes coef_data into coefficient slot coef_idx (0..31), and the slot keeps its value across commands. While busy, coef_we is ignored.
- R4: The column pass uses slots i, 4+i, 8+i and 12+i for column i, with m(x,K) = (x*K) arithmetically shifted right by 16, K1 = 85627 and K2 = 35468. It forms a = s0+s8, b = s0-s8, c = m(s4,K2)-m(s12,K1) and d = m(s4,K1)+m(s12,K2), and stores a+d, b+c, b-c and a-d into temporaries 4i..4i+3.
- R5: The row pass for row i takes temporaries i, 4+i, 8+i and 12+i. It adds 4 to the first of these only, then applies the same butterfly. Columns 0..3 of row i get a+d, b+c, b-c and a-d.
- R6: Each written pixel equals the predicted pixel plus the row value arithmetically shifted right by 3. A negative sum becomes 0 and a sum above 255 becomes 255.
- R7: The pixel in column x and row y of the first block is at byte address base_addr + x + 32*y, for both the read and the write. No byte outside the block is written.
- R8: With two_blk set, a second block is reconstructed after the first. It uses slots 16..31, and its addresses are 4 bytes above the first block's.
- R9: Each wr_en cycle writes the address that rd_en read in the previous cycle, and a read and a write in the same cycle never share an address. A block reconstructed in place therefore matches one reconstructed from a separate copy.
- R10: done is high for exactly one cycle, in the last busy cycle and after the final write. One block keeps busy high for 22 cycles and two blocks keep it high for 43 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a command (honoured only when idle) |
| two_blk | input | 1 | Reconstruct a second block 4 columns to the right |
| base_addr | input | ADDR_W | Byte address of the first block's top-left pixel |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| coef_we | input | 1 | Coefficient slot write strobe |
| coef_idx | input | 5 | Coefficient slot index |
| coef_data | input | COEF_W | Signed coefficient value |
| rd_en | output | 1 | Predicted pixel read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_data | input | PIX_W | Read data, valid the cycle after rd_en |
| wr_en | output | 1 | Pixel write strobe |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | PIX_W | Reconstructed pixel |

## Verification
The hardest condition to reach is a coefficient pattern whose row products exceed 32 bits before the 16-bit shift, because it only appears with coefficients near full scale. The stimulus covers it with a directed run in which every coefficient is ±32767. Clamping at both ends is forced by a large positive or negative DC coefficient over predicted pixels near 255 or near 0. A start pulse and a coefficient write are both injected in the middle of a running command. The result of that command is then checked, and a second run without reloading shows that the slot kept its old value.

// File: rtl/itx4_pkg.sv
package itx4_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_COL  = 2'd1,
        ST_ROW  = 2'd2,
        ST_FIN  = 2'd3
    } itx_state_e;

    localparam int unsigned MUL_K1   = 85627;
    localparam int unsigned MUL_K2   = 35468;
    localparam int unsigned FRAC_SH  = 16;
    localparam int unsigned OUT_SH   = 3;
    localparam int unsigned ROW_RND  = 4;
    localparam int unsigned TAPS     = 4;
    localparam int unsigned BLK_PIX  = TAPS * TAPS;
endpackage

// File: rtl/itx4_bfly.sv
module itx4_bfly
    import itx4_pkg::*;
#(
    parameter int W   = 32,
    parameter int RND = 0
) (
    input  logic signed [W-1:0] s0,
    input  logic signed [W-1:0] s1,
    input  logic signed [W-1:0] s2,
    input  logic signed [W-1:0] s3,
    output logic signed [W-1:0] o0,
    output logic signed [W-1:0] o1,
    output logic signed [W-1:0] o2,
    output logic signed [W-1:0] o3
);
    localparam int PW = W + 18;
    localparam logic signed [PW-1:0] K1    = PW'(MUL_K1);
    localparam logic signed [PW-1:0] K2    = PW'(MUL_K2);
    localparam logic signed [W-1:0]  RND_W = W'(RND);

    function automatic logic signed [W-1:0] fmul(input logic signed [W-1:0] x,
                                                 input logic signed [PW-1:0] k);
        logic signed [PW-1:0] xe;
        logic signed [PW-1:0] p;
        xe = {{(PW-W){x[W-1]}}, x};
        p  = (xe * k) >>> FRAC_SH;
        return W'(p);
    endfunction

    logic signed [W-1:0] dc, a, b, c, d;

    always_comb begin
        dc = s0 + RND_W;
        a  = dc + s2;
        b  = dc - s2;
        c  = fmul(s1, K2) - fmul(s3, K1);
        d  = fmul(s1, K1) + fmul(s3, K2);
        o0 = a + d;
        o1 = b + c;
        o2 = b - c;
        o3 = a - d;
    end
endmodule

// File: rtl/itx4_sat.sv
module itx4_sat
    import itx4_pkg::*;
#(
    parameter int W     = 32,
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0]    ref_px,
    input  logic signed [W-1:0] val,
    output logic [PIX_W-1:0]    px
);
    localparam logic signed [W:0] PMAX = (W+1)'((1 << PIX_W) - 1);

    logic signed [W:0] scaled, ref_ext, sum;

    always_comb begin
        scaled  = $signed({val[W-1], val}) >>> OUT_SH;
        ref_ext = $signed({{(W+1-PIX_W){1'b0}}, ref_px});
        sum     = scaled + ref_ext;
        if (sum < 0)
            px = '0;
        else if (sum > PMAX)
            px = '1;
        else
            px = sum[PIX_W-1:0];
    end
endmodule

// File: rtl/itx4_recon.sv
module itx4_recon
    import itx4_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int ACC_W  = 32,
    parameter int PIX_W  = 8,
    parameter int ADDR_W = 10,
    parameter int PITCH  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     two_blk,
    input  logic [ADDR_W-1:0]        base_addr,
    output logic                     busy,
    output logic                     done,
    input  logic                     coef_we,
    input  logic [4:0]               coef_idx,
    input  logic [COEF_W-1:0]        coef_data,
    output logic                     rd_en,
    output logic [ADDR_W-1:0]        rd_addr,
    input  logic [PIX_W-1:0]         rd_data,
    output logic                     wr_en,
    output logic [ADDR_W-1:0]        wr_addr,
    output logic [PIX_W-1:0]         wr_data
);
    localparam int NCOEF = 2 * BLK_PIX;
    localparam int CNT_W = $clog2(BLK_PIX + 1);
    localparam logic [CNT_W-1:0] ROW_END = CNT_W'(BLK_PIX);

    typedef struct packed {
        itx_state_e                          st;
        logic                                blk;
        logic                                two;
        logic [CNT_W-1:0]                    cnt;
        logic [ADDR_W-1:0]                   base;
        logic [NCOEF-1:0][COEF_W-1:0]        coef;
        logic [BLK_PIX-1:0][ACC_W-1:0]       tmp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    function automatic logic signed [ACC_W-1:0] sext(input logic [COEF_W-1:0] v);
        return {{(ACC_W-COEF_W){v[COEF_W-1]}}, v};
    endfunction

    function automatic logic [ADDR_W-1:0] pix_addr(input logic [ADDR_W-1:0] base,
                                                   input logic blk,
                                                   input logic [1:0] row,
                                                   input logic [1:0] col);
        return base + ADDR_W'({blk, 2'b00}) + ADDR_W'(col)
                    + ADDR_W'(row) * ADDR_W'(PITCH);
    endfunction

    // column / row pointers
    logic [1:0] col_sel;
    logic [3:0] rd_pix, wr_pix;

    assign col_sel = ctl_q.cnt[1:0];
    assign rd_pix  = ctl_q.cnt[3:0];
    assign wr_pix  = ctl_q.cnt[3:0] - 4'd1;

    // butterfly operands
    logic signed [ACC_W-1:0] p1_in [TAPS];
    logic signed [ACC_W-1:0] p2_in [TAPS];

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign p1_in[k] = sext(ctl_q.coef[{ctl_q.blk, 2'(k), col_sel}]);
        assign p2_in[k] = $signed(ctl_q.tmp[{2'(k), wr_pix[3:2]}]);
    end

    logic signed [ACC_W-1:0] p1_o0, p1_o1, p1_o2, p1_o3;
    logic signed [ACC_W-1:0] p2_o0, p2_o1, p2_o2, p2_o3;
    logic signed [ACC_W-1:0] row_val;

    itx4_bfly #(.W(ACC_W), .RND(0)) u_col_bfly (
        .s0(p1_in[0]), .s1(p1_in[1]), .s2(p1_in[2]), .s3(p1_in[3]),
        .o0(p1_o0), .o1(p1_o1), .o2(p1_o2), .o3(p1_o3)
    );

    itx4_bfly #(.W(ACC_W), .RND(ROW_RND)) u_row_bfly (
        .s0(p2_in[0]), .s1(p2_in[1]), .s2(p2_in[2]), .s3(p2_in[3]),
        .o0(p2_o0), .o1(p2_o1), .o2(p2_o2), .o3(p2_o3)
    );

    always_comb begin
        case (wr_pix[1:0])
            2'd0:    row_val = p2_o0;
            2'd1:    row_val = p2_o1;
            2'd2:    row_val = p2_o2;
            default: row_val = p2_o3;
        endcase
    end

    itx4_sat #(.W(ACC_W), .PIX_W(PIX_W)) u_sat (
        .ref_px (rd_data),
        .val    (row_val),
        .px     (wr_data)
    );

    // next-state logic
    always_comb begin
        ctl_d = ctl_q;
        if (coef_we && ctl_q.st == ST_IDLE)
            ctl_d.coef[coef_idx] = coef_data;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st   = ST_COL;
                    ctl_d.blk  = 1'b0;
                    ctl_d.two  = two_blk;
                    ctl_d.base = base_addr;
                    ctl_d.cnt  = '0;
                end
            end
            ST_COL: begin
                ctl_d.tmp[{col_sel, 2'd0}] = p1_o0;
                ctl_d.tmp[{col_sel, 2'd1}] = p1_o1;
                ctl_d.tmp[{col_sel, 2'd2}] = p1_o2;
                ctl_d.tmp[{col_sel, 2'd3}] = p1_o3;
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                if (col_sel == 2'd3) begin
                    ctl_d.st  = ST_ROW;
                    ctl_d.cnt = '0;
                end
            end
            ST_ROW: begin
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                if (ctl_q.cnt == ROW_END) begin
                    ctl_d.cnt = '0;
                    if (ctl_q.two && !ctl_q.blk) begin
                        ctl_d.blk = 1'b1;
                        ctl_d.st  = ST_COL;
                    end else begin
                        ctl_d.st  = ST_FIN;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '0;
        else
            ctl_q <= ctl_d;
    end

    // port drive
    assign busy    = (ctl_q.st != ST_IDLE);
    assign done    = (ctl_q.st == ST_FIN);
    assign rd_en   = (ctl_q.st == ST_ROW) && (ctl_q.cnt != ROW_END);
    assign wr_en   = (ctl_q.st == ST_ROW) && (ctl_q.cnt != '0);
    assign rd_addr = pix_addr(ctl_q.base, ctl_q.blk, rd_pix[3:2], rd_pix[1:0]);
    assign wr_addr = pix_addr(ctl_q.base, ctl_q.blk, wr_pix[3:2], wr_pix[1:0]);
endmodule

// File: rtl/itx4_recon_chk.sv
module itx4_recon_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !wr_en && !done));

    a_r2_start_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r9_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($past(rd_en) && wr_addr == $past(rd_addr)));

    a_r9_no_addr_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |-> (rd_addr != wr_addr));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r10_done_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_en && !rd_en));
endmodule

bind itx4_recon itx4_recon_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr)
);

// File: tb/itx4_recon_tb.sv
`timescale 1ns/1ps
module itx4_recon_tb;
    localparam int AW  = 10;
    localparam int MEM = 1 << AW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0, two_blk = 1'b0;
    logic [AW-1:0]  base_addr = '0;
    logic           busy, done;
    logic           coef_we = 1'b0;
    logic [4:0]     coef_idx = '0;
    logic [15:0]    coef_data = '0;
    logic           rd_en, wr_en;
    logic [AW-1:0]  rd_addr, wr_addr;
    logic [7:0]     rd_data;
    logic [7:0]     wr_data;

    always #2 clk = ~clk;

    itx4_recon u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .two_blk(two_blk),
        .base_addr(base_addr), .busy(busy), .done(done),
        .coef_we(coef_we), .coef_idx(coef_idx), .coef_data(coef_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    logic [7:0] mem  [MEM];
    logic [7:0] snap [MEM];
    logic [7:0] expv [MEM];
    int         coefs [32];
    int         checks = 0;
    int         errors = 0;

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint ex);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, ex);
        end
    endtask

    function automatic longint fm(input longint x, input longint k);
        return (x * k) >>> 16;
    endfunction

    function automatic int clamp8(input longint v);
        if (v < 0) return 0;
        if (v > 255) return 255;
        return int'(v);
    endfunction

    task automatic model(input int base, input bit two);
        longint t [16];
        longint a, b, c, d, dc;
        longint v [4];
        int addr;
        for (int n = 0; n < MEM; n++) expv[n] = snap[n];
        for (int bk = 0; bk <= int'(two); bk++) begin
            for (int i = 0; i < 4; i++) begin   // R4 column pass
                a = coefs[16*bk+i] + coefs[16*bk+8+i];
                b = coefs[16*bk+i] - coefs[16*bk+8+i];
                c = fm(coefs[16*bk+4+i], 35468) - fm(coefs[16*bk+12+i], 85627);
                d = fm(coefs[16*bk+4+i], 85627) + fm(coefs[16*bk+12+i], 35468);
                t[4*i] = a + d; t[4*i+1] = b + c; t[4*i+2] = b - c; t[4*i+3] = a - d;
            end
            for (int i = 0; i < 4; i++) begin   // R5 row pass
                dc = t[i] + 4;
                a = dc + t[8+i];
                b = dc - t[8+i];
                c = fm(t[4+i], 35468) - fm(t[12+i], 85627);
                d = fm(t[4+i], 85627) + fm(t[12+i], 35468);
                v[0] = a + d; v[1] = b + c; v[2] = b - c; v[3] = a - d;
                for (int x = 0; x < 4; x++) begin
                    addr = base + 4*bk + x + 32*i;     // R7 R8
                    expv[addr] = 8'(clamp8(longint'(snap[addr]) + (v[x] >>> 3)));  // R6
                end
            end
        end
    endtask

    task automatic load_coefs();
        for (int i = 0; i < 32; i++) begin
            coef_we   = 1'b1;
            coef_idx  = 5'(i);
            coef_data = 16'(coefs[i]);
            @(posedge clk); #1;
        end
        coef_we = 1'b0;
    endtask

    task automatic run(input string tag, input int base, input bit two, input bit poke);
        int bcyc = 0, dcnt = 0, dpos = -1, addr;
        for (int n = 0; n < MEM; n++) snap[n] = mem[n];
        model(base, two);
        start = 1'b1; base_addr = AW'(base); two_blk = two;
        @(posedge clk); #1;
        start = 1'b0;
        forever begin
            @(negedge clk);
            if (!busy) break;
            bcyc++;
            if (done) begin dcnt++; dpos = bcyc; end
            if (poke && bcyc == 5) begin   // R2 R3: start and coef write while busy
                start = 1'b1; base_addr = AW'(512); two_blk = ~two;
                coef_we = 1'b1; coef_idx = 5'd0; coef_data = 16'd12345;
            end
            if (poke && bcyc == 6) begin
                start = 1'b0; coef_we = 1'b0;
            end
            if (bcyc > 2000) break;
        end
        chk(bcyc == (two ? 43 : 22), {tag, " R10 busy cycles"}, bcyc, two ? 43 : 22);
        chk(dcnt == 1, {tag, " R10 done pulse count"}, dcnt, 1);
        chk(dpos == bcyc, {tag, " R10 done in last busy cycle"}, dpos, bcyc);
        for (int bk = 0; bk <= int'(two); bk++)
            for (int y = 0; y < 4; y++)
                for (int x = 0; x < 4; x++) begin
                    addr = base + 4*bk + x + 32*y;
                    chk(mem[addr] == expv[addr], {tag, " R4/R5/R6 pixel"},
                        mem[addr], expv[addr]);
                end
        addr = base + (two ? 8 : 4);
        chk(mem[addr] == snap[addr], {tag, " R7/R8 neighbour untouched"}, mem[addr], snap[addr]);
        addr = base + 128;
        if (addr < MEM)
            chk(mem[addr] == snap[addr], {tag, " R7 row below untouched"}, mem[addr], snap[addr]);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c0de));
        for (int n = 0; n < MEM; n++) mem[n] = 8'($urandom);
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && !rd_en && !wr_en, "R1 reset outputs idle",
            {busy, done, rd_en, wr_en}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // zero residual: output equals prediction
        for (int i = 0; i < 32; i++) coefs[i] = 0;
        load_coefs();
        run("zero", 100, 1'b0, 1'b0);

        // clamp high (R6)
        coefs[0] = 2000;
        load_coefs();
        for (int y = 0; y < 4; y++) for (int x = 0; x < 4; x++) mem[200 + x + 32*y] = 8'(240 + x);
        run("sat_hi", 200, 1'b0, 1'b0);

        // clamp low (R6)
        coefs[0] = -2000;
        load_coefs();
        for (int y = 0; y < 4; y++) for (int x = 0; x < 4; x++) mem[300 + x + 32*y] = 8'(5 + x);
        run("sat_lo", 300, 1'b0, 1'b0);

        // full-scale coefficients, both blocks (R8)
        for (int i = 0; i < 32; i++) coefs[i] = ($urandom & 1) ? 32767 : -32767;
        load_coefs();
        run("extreme", 640, 1'b1, 1'b0);

        // second block uses upper slots only (R8)
        for (int i = 0; i < 32; i++) coefs[i] = (i >= 16) ? int'($urandom_range(600)) - 300 : 0;
        load_coefs();
        run("upper_only", 10, 1'b1, 1'b0);

        // start and coef write while busy are ignored (R2 R3)
        for (int i = 0; i < 32; i++) coefs[i] = int'($urandom_range(400)) - 200;
        load_coefs();
        for (int n = 0; n < MEM; n++) snap[n] = mem[n];
        begin
            logic [7:0] keep0, keep1;
            keep0 = mem[512]; keep1 = mem[516];
            run("busy_poke", 0, 1'b0, 1'b1);
            chk(mem[512] == keep0 && mem[516] == keep1, "R2 second start wrote nothing",
                mem[512], keep0);
        end
        run("coef_kept", 256, 1'b0, 1'b0);   // R3: slot 0 still holds loaded value

        // random mix
        for (int r = 0; r < 24; r++) begin
            for (int i = 0; i < 32; i++)
                coefs[i] = (r % 3 == 0) ? int'($urandom_range(65535)) - 32768
                                         : int'($urandom_range(800)) - 400;
            load_coefs();
            run("random", int'($urandom_range(919)), 1'($urandom), 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule